// File: doc/BRIEF.md
# Rising-Edge Gap Classifier with Frame Header Search

This block sits behind the comparator of a low-frequency tag reader. It takes the digitized, demodulated data line, passes it through a synchronizer and measures the time from one rising edge to the next. The time base is a tick enable that arrives once per 8 us. Each completed gap is placed in one of four classes, and a one-cycle valid strobe goes with the class. A gap of about 530 us is short. A gap of about 800 us is medium. A gap of about 1060 us is long. Gaps outside the usable band are invalid. A gap of medium length can come from two different Manchester transitions that cannot be told apart by length. The block therefore reports it as one ambiguous class, and a later bit decoder resolves it.

The same class stream feeds a header search. A frame starts with a zero followed by nine ones, which shows up as one medium or long gap followed by eight short gaps. When that pattern completes, the block raises a one-cycle pulse. It then holds off further pulses. A data pattern of a one followed by ten or more zeros produces the same gaps, so a downstream parity check can reject the candidate. It then asserts a restart request, which clears the search so that the next candidate can be found.

Top module: `gap_header_detect`

## Requirements
- R1: The data input passes through a two-flop synchronizer. Each rising edge of the input produces at most one gap event. Falling edges never produce a class output.
- R2: The first rising edge after reset only starts timing and reports nothing. Each later rising edge produces `class_valid` for exactly one cycle. The pulse appears in the cycle after the third rising clock edge that follows the input change.
- R3: The gap length is the number of clock edges with `tick_en` high, counted from the edge that registers one rising edge up to, but not including, the edge that registers the next one. Edges with `tick_en` low are not counted.
- R4: The gap counter saturates at 255 and does not wrap. A gap of 255 ticks or more is reported as invalid.
- R5: `class_code` encodings are as follows. 0 means short (40 to 83 ticks). 1 means medium, ambiguous between the two 800 us cases (84 to 116 ticks). 2 means long (117 to 160 ticks). 3 means invalid (under 40 or over 160 ticks).
- R6: A medium or long gap followed by eight consecutive short gaps raises `hdr_found` for one cycle. The pulse comes in the cycle after the `class_valid` of the eighth short gap.
- R7: An invalid gap clears the header search. Short gaps that are not preceded by a medium or long gap never complete a header.
- R8: After `hdr_found`, no further `hdr_found` occurs until `rearm` is pulsed. `rearm` clears any partial search, so a new medium or long gap is needed. When `rearm` and a class event coincide, `rearm` wins and the event is dropped by the search.
- R9: A medium or long gap that arrives in the middle of a run of short gaps restarts the count of short gaps from zero.
- R10: During and right after reset, `class_valid` and `hdr_found` are low and `class_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| tick_en | input | 1 | Time-base enable, one cycle high per 8 us |
| data_in | input | 1 | Asynchronous demodulated data line |
| rearm | input | 1 | Restart request for the header search |
| class_code | output | 2 | Class of the last completed gap |
| class_valid | output | 1 | One-cycle strobe qualifying class_code |
| hdr_found | output | 1 | One-cycle pulse when a header candidate is seen |

## Verification
A gap counter that is wrong, or that wraps instead of saturating, shows up as a wrong `class_code` on the very next rising edge. Gaps placed on each class boundary and a gap far beyond saturation expose it within one gap. A header search state that is out of step with the class stream shows up as a missing, early or extra `hdr_found` one cycle after the class strobe that should or should not complete the run. Runs that are broken by invalid gaps, restarted by medium gaps, cut by `rearm` or seen while locked expose this within the same frame. A synchronizer or edge detector with the wrong latency moves every strobe off the cycle the bench expects, so this shows up on the first reported gap.

// File: rtl/egc_pkg.sv
package egc_pkg;

  typedef enum logic [1:0] {
    GAP_SHORT = 2'd0,
    GAP_MID   = 2'd1,
    GAP_LONG  = 2'd2,
    GAP_BAD   = 2'd3
  } gap_class_e;

  // Sort a tick count into a class using inclusive band limits.
  function automatic gap_class_e classify_gap(
    input int unsigned ticks,
    input int unsigned short_min,
    input int unsigned short_max,
    input int unsigned mid_max,
    input int unsigned long_max
  );
    if (ticks < short_min || ticks > long_max) return GAP_BAD;
    if (ticks <= short_max)                     return GAP_SHORT;
    if (ticks <= mid_max)                       return GAP_MID;
    return GAP_LONG;
  endfunction

endpackage

// File: rtl/egc_sync_rise.sv
module egc_sync_rise #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;
  logic              synced;

  assign synced = chain[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain  <= '0;
      last_q <= 1'b0;
    end else begin
      chain  <= {chain[STAGES-2:0], din};
      last_q <= synced;
    end
  end

  assign rise = synced & ~last_q;

  // R1: an edge event never lasts two cycles
  assert_rise_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/egc_gap_timer.sv
module egc_gap_timer
  import egc_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int SHORT_MIN = 40,
  parameter int SHORT_MAX = 83,
  parameter int MID_MAX   = 116,
  parameter int LONG_MAX  = 160
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       rise,
  output logic       cls_valid,
  output gap_class_e cls_code
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] gap_cnt;
  logic             seen_edge;
  logic             at_max;

  assign at_max = (gap_cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_cnt   <= '0;
      seen_edge <= 1'b0;
      cls_valid <= 1'b0;
      cls_code  <= GAP_SHORT;
    end else if (rise) begin
      seen_edge <= 1'b1;
      cls_valid <= seen_edge;
      cls_code  <= classify_gap(32'(gap_cnt), SHORT_MIN, SHORT_MAX, MID_MAX, LONG_MAX);
      gap_cnt   <= tick_en ? CNT_W'(1) : '0;
    end else begin
      cls_valid <= 1'b0;
      if (tick_en && !at_max) gap_cnt <= gap_cnt + CNT_W'(1);
    end
  end

  // R4: a saturated counter stays saturated until the next edge
  assert_sat_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (at_max && !rise) |=> at_max);

  // R2: a class strobe only follows an edge event
  assert_valid_after_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cls_valid |-> $past(rise));

endmodule

// File: rtl/egc_hdr_search.sv
module egc_hdr_search
  import egc_pkg::*;
#(
  parameter int HDR_SHORTS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rearm,
  input  logic       cls_valid,
  input  gap_class_e cls_code,
  output logic       hdr_found
);
  localparam int RUN_W = (HDR_SHORTS > 1) ? $clog2(HDR_SHORTS) : 1;
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(HDR_SHORTS - 1);

  logic             armed;
  logic             locked;
  logic [RUN_W-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      locked    <= 1'b0;
      run_cnt   <= '0;
      hdr_found <= 1'b0;
    end else begin
      hdr_found <= 1'b0;
      if (rearm) begin
        armed   <= 1'b0;
        locked  <= 1'b0;
        run_cnt <= '0;
      end else if (cls_valid && !locked) begin
        unique case (cls_code)
          GAP_BAD: begin
            armed   <= 1'b0;
            run_cnt <= '0;
          end
          GAP_MID, GAP_LONG: begin
            armed   <= 1'b1;
            run_cnt <= '0;
          end
          GAP_SHORT: begin
            if (armed) begin
              if (run_cnt == RUN_LAST) begin
                hdr_found <= 1'b1;
                locked    <= 1'b1;
                armed     <= 1'b0;
                run_cnt   <= '0;
              end else begin
                run_cnt <= run_cnt + RUN_W'(1);
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R6: a header completes only on a short gap
  assert_hdr_after_short_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_found |-> $past(cls_valid && cls_code == GAP_SHORT));

  // R6: the header flag is a single-cycle pulse
  assert_hdr_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_found |=> !hdr_found);

  // R8: no header while locked and not being rearmed
  assert_locked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !rearm) |=> !hdr_found);

endmodule

// File: rtl/gap_header_detect.sv
module gap_header_detect
  import egc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8,
  parameter int SHORT_MIN   = 40,
  parameter int SHORT_MAX   = 83,
  parameter int MID_MAX     = 116,
  parameter int LONG_MAX    = 160,
  parameter int HDR_SHORTS  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       data_in,
  input  logic       rearm,
  output logic [1:0] class_code,
  output logic       class_valid,
  output logic       hdr_found
);
  logic       rise_evt;
  logic       cls_valid_w;
  gap_class_e cls_code_w;
  logic       hdr_w;

  egc_sync_rise #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (data_in),
    .rise (rise_evt)
  );

  egc_gap_timer #(
    .CNT_W    (CNT_W),
    .SHORT_MIN(SHORT_MIN),
    .SHORT_MAX(SHORT_MAX),
    .MID_MAX  (MID_MAX),
    .LONG_MAX (LONG_MAX)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .rise     (rise_evt),
    .cls_valid(cls_valid_w),
    .cls_code (cls_code_w)
  );

  egc_hdr_search #(.HDR_SHORTS(HDR_SHORTS)) u_hdr (
    .clk      (clk),
    .rst_n    (rst_n),
    .rearm    (rearm),
    .cls_valid(cls_valid_w),
    .cls_code (cls_code_w),
    .hdr_found(hdr_w)
  );

  assign class_code  = cls_code_w;
  assign class_valid = cls_valid_w;
  assign hdr_found   = hdr_w;

endmodule

// File: tb/gap_header_detect_tb.sv
module gap_header_detect_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b1;
  logic       data_in = 1'b0;
  logic       rearm = 1'b0;
  logic [1:0] class_code;
  logic       class_valid;
  logic       hdr_found;

  gap_header_detect u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .data_in(data_in),
    .rearm(rearm), .class_code(class_code), .class_valid(class_valid),
    .hdr_found(hdr_found)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  int    exp_cls [0:2047];
  int    exp_due [0:2047];
  string exp_tag [0:2047];
  int    wr = 0;
  int    rd = 0;

  bit    m_armed = 0, m_locked = 0;
  int    m_run = 0;
  bit    hdr_next = 0;
  string hdr_tag = "R6";
  bit    prev_half = 0;
  bit    mon_on = 0;
  bit    done = 0;

  function automatic int exp_class(input int ticks);
    int t = (ticks > 255) ? 255 : ticks;
    if (t < 40 || t > 160) return 3;
    if (t >= 117) return 2;
    if (t >= 84) return 1;
    return 0;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // One gap of g cycles between input rises; half selects ticks on alternate cycles.
  task automatic send_gap(input int g, input bit half, input bit do_rearm, input string tag);
    int h = g / 2;
    for (int i = 1; i <= g; i++) begin
      @(negedge clk);
      if (i == 1) tick_en = prev_half ? 1'b0 : 1'b1;
      else        tick_en = half ? ((i % 2) == 0) : 1'b1;
      if (do_rearm && i == h) begin
        rearm = 1'b1;
        m_armed = 0; m_locked = 0; m_run = 0;
      end else if (do_rearm && i == h + 1) begin
        rearm = 1'b0;
      end
      if (i == h) data_in = 1'b0;
      if (i == g) begin
        data_in = 1'b1;
        exp_cls[wr] = exp_class(half ? g / 2 : g);
        exp_due[wr] = cyc + 3;
        exp_tag[wr] = tag;
        wr++;
      end
    end
    prev_half = half;
  endtask

  // Monitor: class stream, latency and header expectations
  always @(negedge clk) begin
    if (mon_on) begin
      if (hdr_next || hdr_found)
        check(hdr_found == hdr_next, hdr_tag, "hdr_found", int'(hdr_found), int'(hdr_next));
      hdr_next = 0;
      if (class_valid) begin
        if (rd >= wr) begin
          check(1'b0, "R1", "unexpected class event", 1, 0);
        end else begin
          check(int'(class_code) == exp_cls[rd], exp_tag[rd], "class_code",
                int'(class_code), exp_cls[rd]);
          check(cyc == exp_due[rd], "R2", "strobe cycle", cyc, exp_due[rd]);
          if (!m_locked) begin
            case (exp_cls[rd])
              3: begin m_armed = 0; m_run = 0; end
              1, 2: begin m_armed = 1; m_run = 0; end
              default: if (m_armed) begin
                m_run++;
                if (m_run == 8) begin
                  hdr_next = 1; m_locked = 1; m_armed = 0; m_run = 0;
                end
              end
            endcase
          end
          hdr_tag = exp_tag[rd];
          rd++;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1));
    repeat (5) @(negedge clk);
    check(class_valid == 1'b0, "R10", "class_valid in reset", int'(class_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(class_valid == 1'b0, "R10", "class_valid after reset", int'(class_valid), 0);
    check(hdr_found == 1'b0, "R10", "hdr_found after reset", int'(hdr_found), 0);
    check(class_code == 2'd0, "R10", "class_code after reset", int'(class_code), 0);
    mon_on = 1;

    // first rise: starts timing only (R2)
    @(negedge clk);
    data_in = 1'b1;

    // class boundaries (R5)
    send_gap(39, 0, 0, "R5");  send_gap(40, 0, 0, "R5");
    send_gap(83, 0, 0, "R5");  send_gap(84, 0, 0, "R5");
    send_gap(116, 0, 0, "R5"); send_gap(117, 0, 0, "R5");
    send_gap(160, 0, 0, "R5"); send_gap(161, 0, 0, "R5");

    // header found (R6)
    send_gap(130, 0, 0, "R6");
    for (int k = 0; k < 8; k++) send_gap(50 + k * 4, 0, 0, "R6");

    // locked: second header ignored (R8)
    send_gap(100, 0, 0, "R8");
    for (int k = 0; k < 8; k++) send_gap(60, 0, 0, "R8");

    // rearm then new header (R8)
    send_gap(60, 0, 1, "R8");
    send_gap(140, 0, 0, "R8");
    for (int k = 0; k < 8; k++) send_gap(70, 0, 0, "R8");

    // rearm mid-run clears partial count (R8)
    send_gap(60, 0, 1, "R8");
    send_gap(130, 0, 0, "R8");
    for (int k = 0; k < 4; k++) send_gap(60, 0, 0, "R8");
    send_gap(60, 0, 1, "R8");
    for (int k = 0; k < 4; k++) send_gap(60, 0, 0, "R8");

    // invalid gap breaks the run; shorts alone never match (R7)
    send_gap(150, 0, 0, "R7");
    for (int k = 0; k < 3; k++) send_gap(60, 0, 0, "R7");
    send_gap(25, 0, 0, "R7");
    for (int k = 0; k < 9; k++) send_gap(60, 0, 0, "R7");

    // medium gap restarts the short count (R9)
    send_gap(125, 0, 0, "R9");
    for (int k = 0; k < 5; k++) send_gap(60, 0, 0, "R9");
    send_gap(100, 0, 0, "R9");
    for (int k = 0; k < 8; k++) send_gap(60, 0, 0, "R9");

    // saturation: no wrap to a short class (R4)
    send_gap(316, 0, 1, "R4");
    send_gap(300, 0, 0, "R4");

    // tick enable gating (R3)
    send_gap(120, 1, 0, "R3");
    send_gap(200, 1, 0, "R3");
    send_gap(240, 1, 0, "R3");
    send_gap(120, 0, 0, "R3");

    // constrained random gaps with header bursts
    for (int n = 0; n < 150; n++) begin
      bit rr = (($urandom % 6) == 0);
      if (($urandom % 8) == 0) begin
        send_gap(117 + int'($urandom % 44), 0, rr, "R6");
        for (int k = 0; k < 8; k++) send_gap(40 + int'($urandom % 44), 0, 0, "R6");
      end else begin
        send_gap(30 + int'($urandom % 140), 0, rr, "R5");
      end
    end

    repeat (8) @(negedge clk);
    check(rd == wr, "R1", "events delivered", rd, wr);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule